// File: doc/BRIEF.md
# Divider and Programmable Interval Timer

This block keeps a free-running prescaler whose upper byte is visible as an 8-bit divider, and an 8-bit interval counter that advances at one of four rates taken from that prescaler. When the counter passes its all-ones value, it reloads from a modulo register and raises a one-clock interrupt request. A system tick input acts as a clock enable, so each asserted `tick_i` counts as one system clock. A fast-mode input makes every tick advance the prescaler by two, which doubles both the divider and the timer rate.

Software controls the block through a single write port with a 2-bit register select. The divider, counter, modulo and control registers are also driven straight onto output ports, where they can be read back.

Top module: `tmr_div_top`

## Requirements
- R1: After a synchronous active-low reset, the divider, counter, modulo and control values are all 0 and `irq_o` is low.
- R2: In normal mode, each asserted `tick_i` advances the prescaler by one, and `div_o` increments once every 256 ticks.
- R3: When `fast_i` is high, each tick advances the prescaler by two, so `div_o` increments every 128 ticks and the timer period in ticks is halved.
- R4: A write to select 0 (divider) clears the divider and the whole prescaler, whatever the write data is.
- R5: Control bit 2 enables the timer. While it is 0, the counter holds its value.
- R6: Control bits 1:0 choose the counter increment period, counted in prescaler units from a cleared prescaler: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256.
- R7: An increment while the counter holds 0xFF loads the modulo value and drives `irq_o` high for exactly one clock, in the same cycle as the reload.
- R8: A write to select 1 (counter) takes priority over a same-cycle increment or overflow. The written value is stored and no interrupt is raised.
- R9: A write to select 2 (modulo) in the overflow cycle takes effect at once: the reload uses the newly written value.
- R10: With `tick_i` low and no write, the divider and counter do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Clock enable, one system tick |
| fast_i | input | 1 | Fast mode: prescaler steps by two per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| wr_data_i | input | 8 | Write data |
| div_o | output | 8 | Divider value |
| cnt_o | output | 8 | Timer counter value |
| mod_o | output | 8 | Modulo reload value |
| ctl_o | output | 3 | Control: bit 2 enable, bits 1:0 rate select |
| irq_o | output | 1 | One-clock timer interrupt request |

## Verification
The one-clock interrupt property relies on two overflows never landing on adjacent clocks. That holds because the shortest period is 16 prescaler units and a tick adds at most two. The bench keeps `fast_i` constant within each test phase, so the tick counts it expects stay exact. The write-priority properties assume that only one register is written per cycle, which the single write port already guarantees. The bench drives every overlap of a write with an increment on a tick that it has counted to land exactly on the counter's edge.

// File: rtl/tmr_pkg.sv
// Shared definitions for the divider/timer block: register selects and
// the prescaler bit that each rate select taps.
package tmr_pkg;

    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    localparam int NUM_RATES = 4;
    localparam int SEL_W     = 2;
    localparam int CTL_W     = 3;
    localparam int EN_BIT    = 2;

    // Prescaler bit whose toggle marks one counter period for a select value.
    function automatic int rate_tap(input int sel);
        case (sel)
            0:       return 10;
            1:       return 4;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Free-running prescaler. It advances by 1 (or by 2 in fast mode) on each
// enabled tick, shows its upper bits as the divider, and flags, for each
// rate tap, the ticks on which that tap bit toggles.
// Assumes that the step (at most 2) is below 2**tap for every tap, so that
// no tap can wrap twice in one tick.
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 fast_i,
    input  logic                 clr_i,
    output logic [DIV_W-1:0]     div_o,
    output logic [NUM_RATES-1:0] rate_hit_o
);

    localparam int DIV_LSB = PRE_W - DIV_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_step;
    logic [PRE_W-1:0] pre_nx;

    // Step size and candidate next value of the prescaler.
    always_comb begin
        pre_step = fast_i ? PRE_W'(2) : PRE_W'(1);
        pre_nx   = pre_q + pre_step;
    end

    // Prescaler register: a clear beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_nx;
        end
    end

    // One edge detector per rate tap.
    generate
        for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
            localparam int TAP = rate_tap(g);
            assign rate_hit_o[g] = tick_i && !clr_i && (pre_nx[TAP] != pre_q[TAP]);
        end
    endgenerate

    assign div_o = pre_q[PRE_W-1:DIV_LSB];

    // A divider write leaves the prescaler at zero on the next clock.
    assert_div_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));

    // Without a tick or a clear, the prescaler holds.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(pre_q));

    // A tick with no clear moves the prescaler.
    assert_tick_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i) |=> !$stable(pre_q));

endmodule

// File: rtl/tmr_counter.sv
// Interval counter with its modulo reload register and control register.
// It counts on the selected rate hit while enabled, reloads on overflow and
// registers a one-clock interrupt request.
// Assumes that at most one of the write strobes is high in any cycle.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] rate_hit_i,
    input  logic                 wr_cnt_i,
    input  logic                 wr_mod_i,
    input  logic                 wr_ctl_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CNT_W-1:0]     mod_o,
    output logic [CTL_W-1:0]     ctl_o,
    output logic                 irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_q;
    logic [CTL_W-1:0] ctl_q;
    logic             irq_q;
    logic             inc;
    logic             wrap;
    logic [CNT_W-1:0] mod_nx;

    // Increment and overflow decode; the reload sees a same-cycle modulo write.
    always_comb begin
        inc    = ctl_q[EN_BIT] && rate_hit_i[ctl_q[SEL_W-1:0]];
        wrap   = inc && (cnt_q == '1);
        mod_nx = wr_mod_i ? wr_data_i : mod_q;
    end

    // Counter: a software write beats reload, and reload beats increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt_i) begin
            cnt_q <= wr_data_i;
        end else if (wrap) begin
            cnt_q <= mod_nx;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Modulo and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            ctl_q <= '0;
        end else begin
            mod_q <= mod_nx;
            if (wr_ctl_i) begin
                ctl_q <= wr_data_i[CTL_W-1:0];
            end
        end
    end

    // Interrupt request, suppressed when a counter write wins the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap && !wr_cnt_i;
        end
    end

    assign cnt_o = cnt_q;
    assign mod_o = mod_q;
    assign ctl_o = ctl_q;
    assign irq_o = irq_q;

    // The request never lasts longer than one clock.
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // While a request is high, the counter holds the reload value.
    assert_irq_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == mod_q));

    // A counter write is stored and silences the interrupt.
    assert_cnt_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> ((cnt_q == $past(wr_data_i)) && !irq_q));

    // A disabled timer holds its counter.
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[EN_BIT] && !wr_cnt_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_div_top.sv
// Divider and interval timer top. It decodes the single write port into
// per-register strobes and joins the prescaler to the interval counter.
// Assumes that tick_i and fast_i are synchronous to clk.
module tmr_div_top
    import tmr_pkg::*;
#(
    parameter int PRE_W = 16,
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fast_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [DIV_W-1:0] div_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             irq_o
);

    reg_sel_e             sel;
    logic                 wr_div;
    logic                 wr_cnt;
    logic                 wr_mod;
    logic                 wr_ctl;
    logic [NUM_RATES-1:0] rate_hit;

    // Write-port decode into one strobe per register.
    always_comb begin
        sel    = reg_sel_e'(wr_addr_i);
        wr_div = wr_en_i && (sel == REG_DIV);
        wr_cnt = wr_en_i && (sel == REG_CNT);
        wr_mod = wr_en_i && (sel == REG_MOD);
        wr_ctl = wr_en_i && (sel == REG_CTL);
    end

    tmr_prescaler #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .fast_i     (fast_i),
        .clr_i      (wr_div),
        .div_o      (div_o),
        .rate_hit_o (rate_hit)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_hit_i (rate_hit),
        .wr_cnt_i   (wr_cnt),
        .wr_mod_i   (wr_mod),
        .wr_ctl_i   (wr_ctl),
        .wr_data_i  (wr_data_i),
        .cnt_o      (cnt_o),
        .mod_o      (mod_o),
        .ctl_o      (ctl_o),
        .irq_o      (irq_o)
    );

endmodule

// File: tb/tmr_div_top_tb.sv
// Scoreboard bench: driver tasks push expected output values, and a monitor
// at the falling edge pops and compares them against the outputs.
module tmr_div_top_tb;

    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       fast = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] div_o;
    logic [7:0] cnt_o;
    logic [7:0] mod_o;
    logic [2:0] ctl_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         which;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    tmr_div_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .fast_i    (fast),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .div_o     (div_o),
        .cnt_o     (cnt_o),
        .mod_o     (mod_o),
        .ctl_o     (ctl_o),
        .irq_o     (irq_o)
    );

    function automatic logic [7:0] pick(input int which);
        case (which)
            0:       return div_o;
            1:       return cnt_o;
            2:       return mod_o;
            3:       return {5'd0, ctl_o};
            default: return {7'd0, irq_o};
        endcase
    endfunction

    // Monitor: compare every queued expectation away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = pick(it.which);
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: output %0d actual 0x%02h expected 0x%02h",
                         it.req, it.which, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int which, input logic [7:0] exp, input string req);
        item_t it;
        it.which = which;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic cyc(input logic t, input logic we, input logic [1:0] a, input logic [7:0] d);
        tick = t;
        wr_en = we;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        tick = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        expect_val(0, 8'h00, "R1");
        expect_val(1, 8'h00, "R1");
        expect_val(2, 8'h00, "R1");
        expect_val(3, 8'h00, "R1");
        expect_val(4, 8'h00, "R1");
        cyc(1'b0, 1'b0, 2'd0, 8'd0);

        // R2: divider every 256 ticks
        run(255); expect_val(0, 8'h00, "R2");
        run(1);   expect_val(0, 8'h01, "R2");
        run(768); expect_val(0, 8'h04, "R2");

        // R4: divider write clears whatever the data
        wr(2'd0, 8'hAB); expect_val(0, 8'h00, "R4");
        run(255); expect_val(0, 8'h00, "R4");
        run(1);   expect_val(0, 8'h01, "R4");

        // R6: four rate selects
        wr(2'd3, 8'h05); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        expect_val(3, 8'h05, "R6");
        run(15); expect_val(1, 8'h00, "R6 sel01");
        run(1);  expect_val(1, 8'h01, "R6 sel01");
        run(64); expect_val(1, 8'h05, "R6 sel01");
        wr(2'd3, 8'h06); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        run(63); expect_val(1, 8'h00, "R6 sel10");
        run(1);  expect_val(1, 8'h01, "R6 sel10");
        wr(2'd3, 8'h07); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        run(255); expect_val(1, 8'h00, "R6 sel11");
        run(1);   expect_val(1, 8'h01, "R6 sel11");
        wr(2'd3, 8'h04); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        run(1023); expect_val(1, 8'h00, "R6 sel00");
        run(1);    expect_val(1, 8'h01, "R6 sel00");

        // R5: timer disabled holds the counter
        wr(2'd3, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h07);
        run(100); expect_val(1, 8'h07, "R5");
        run(300); expect_val(1, 8'h07, "R5");

        // R7: overflow reloads and pulses the interrupt once
        wr(2'd3, 8'h05); wr(2'd2, 8'h40); wr(2'd1, 8'hFE); wr(2'd0, 8'h00);
        run(16); expect_val(1, 8'hFF, "R7"); expect_val(4, 8'h00, "R7");
        run(15); expect_val(1, 8'hFF, "R7");
        run(1);  expect_val(1, 8'h40, "R7"); expect_val(4, 8'h01, "R7");
        cyc(1'b0, 1'b0, 2'd0, 8'd0);
        expect_val(4, 8'h00, "R7"); expect_val(1, 8'h40, "R7");

        // R8: a counter write wins over a same-cycle overflow
        wr(2'd2, 8'h10); wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        run(15);
        cyc(1'b1, 1'b1, 2'd1, 8'h33);
        expect_val(1, 8'h33, "R8"); expect_val(4, 8'h00, "R8");
        cyc(1'b0, 1'b0, 2'd0, 8'd0);
        expect_val(4, 8'h00, "R8");

        // R9: a modulo write in the overflow cycle feeds the reload
        wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        run(15);
        cyc(1'b1, 1'b1, 2'd2, 8'h77);
        expect_val(1, 8'h77, "R9"); expect_val(4, 8'h01, "R9");
        expect_val(2, 8'h77, "R9");
        cyc(1'b0, 1'b0, 2'd0, 8'd0);

        // R3: fast mode doubles both rates
        wr(2'd1, 8'h00);
        fast = 1'b1;
        wr(2'd0, 8'h00);
        run(8);   expect_val(1, 8'h01, "R3");
        run(120); expect_val(1, 8'h10, "R3"); expect_val(0, 8'h01, "R3");
        fast = 1'b0;

        // R10: no tick, nothing moves
        for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 2'd0, 8'd0);
        expect_val(0, 8'h01, "R10"); expect_val(1, 8'h10, "R10");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule